// File: doc/BRIEF.md
# Instruction Alignment and Exception-PC Unit

This block keeps the run-time instruction alignment setting of a small core and decides, for every fetch that the front end presents, whether that fetch may go ahead or must raise an instruction-address-misaligned fault. The setting has two values. It is 16-bit alignment while the compressed-instruction extension is enabled, and 32-bit alignment while that extension is disabled. Software changes the setting by writing a single enable bit. A write that disables the extension retires normally. Only fetches issued after it are judged under the stricter rule.

The block also holds the two exception-PC registers, one for machine mode and one for supervisor mode. They are loaded either by a CSR write or by trap entry, and both paths apply the same low-bit masking. Bit 0 never reads as one. Bit 1 reads as zero while the alignment is 32 bits. A build-time option also clears bit 1 in storage when the register is written under 32-bit alignment.

A trap return never faults. It hands back the selected register's visible value one cycle later. If that address turns out to be misaligned, the fault appears on the fetch that follows.

Top module: `ialign_epc_unit`

## Requirements
- R1: After a synchronous reset the compressed extension is enabled (`ialign32_o` = 0), both EPC reads are zero, and `fault_o`, `fetch_go_o` and `ret_valid_o` are 0.
- R2: While `ialign32_o` is 0, every valid fetch produces `fetch_go_o` = 1 and `fault_o` = 0 in the cycle after it is presented, whatever its address.
- R3: While `ialign32_o` is 1, a valid fetch whose address bit 1 is set produces `fault_o` = 1 for exactly one cycle, with `fault_addr_o` equal to that address and `fetch_go_o` = 0. A fetch with bit 1 clear produces `fetch_go_o` = 1 and `fault_o` = 0.
- R4: A write to the compressed-enable bit takes effect at the clock edge that accepts it. A fetch presented in the same cycle as the write is judged by the old setting, and fetches in later cycles are judged by the new one.
- R5: Bit 0 of both EPC read values is always 0.
- R6: A CSR write to an EPC register (`epc_we` bit 0 = machine, bit 1 = supervisor) stores the data. Its read shows bit 1 as 0 while `ialign32_o` is 1. With `HARDWIRE_B1` = 0, a stored bit 1 becomes visible again when the setting returns to 16 bits.
- R7: With `HARDWIRE_B1` = 1, a write made while `ialign32_o` is 1 stores bit 1 as 0, so the bit stays 0 after the setting returns to 16 bits.
- R8: Trap entry loads `trap_pc` into the machine register (`trap_sel` = 0) or the supervisor register (`trap_sel` = 1), with the same masking as a CSR write. It takes precedence over a CSR write to the same register in the same cycle.
- R9: A trap return (`xret`, `xret_sel` 0 = machine, 1 = supervisor) gives `ret_valid_o` = 1 for one cycle on the next cycle, with `ret_pc_o` equal to the selected EPC read value at the time of the return. It never raises `fault_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cext_we | input | 1 | Write strobe for the compressed-enable bit |
| cext_wdata | input | 1 | New compressed-enable value (1 = enabled) |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_addr | input | XLEN | Address of the next fetch |
| trap_enter | input | 1 | Trap entry strobe |
| trap_sel | input | 1 | Trap target register: 0 machine, 1 supervisor |
| trap_pc | input | XLEN | PC captured on trap entry |
| xret | input | 1 | Trap-return strobe |
| xret_sel | input | 1 | Return source register: 0 machine, 1 supervisor |
| epc_we | input | 2 | CSR write strobes: bit 0 machine, bit 1 supervisor |
| epc_wdata | input | XLEN | CSR write data |
| ialign32_o | output | 1 | Current setting: 1 = 32-bit alignment |
| fetch_go_o | output | 1 | Registered: the last fetch may proceed |
| fault_o | output | 1 | Registered: the last fetch is misaligned |
| fault_addr_o | output | XLEN | Address of the faulting fetch |
| mepc_o | output | XLEN | Machine EPC read value |
| sepc_o | output | XLEN | Supervisor EPC read value |
| ret_valid_o | output | 1 | Registered: a trap return completed |
| ret_pc_o | output | XLEN | Address the return resumes at |

## Verification
Fetch verdicts (`fetch_go_o`, `fault_o`, `fault_addr_o`) and return results (`ret_valid_o`, `ret_pc_o`) are registered, so they are due one cycle after the stimulus. The EPC read values and `ialign32_o` change right after the edge that accepts the write. The bench drives inputs after a falling edge and samples after the next falling edge, so each kind of result is read in the cycle where it is due. Setting switches are checked with a fetch in the same cycle as the write and again with a fetch in the cycle after it, and a second instance built with `HARDWIRE_B1` = 1 covers the storage-clearing variant.

// File: rtl/ialign_pkg.sv
package ialign_pkg;
  typedef enum logic {IALIGN_16 = 1'b0, IALIGN_32 = 1'b1} ialign_e;
  typedef enum logic {SEL_M = 1'b0, SEL_S = 1'b1} priv_sel_e;
  localparam int unsigned NUM_EPC = 2;
endpackage

// File: rtl/ialign_ctrl.sv
module ialign_ctrl
  import ialign_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cext_we,
  input  logic    cext_wdata,
  output ialign_e mode_q
);
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= IALIGN_16;
    else if (cext_we) mode_q <= cext_wdata ? IALIGN_16 : IALIGN_32;
  end
endmodule

// File: rtl/fetch_align_chk.sv
module fetch_align_chk
  import ialign_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  ialign_e         mode,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_addr,
  output logic            go_q,
  output logic            fault_q,
  output logic [XLEN-1:0] fault_addr_q
);
  logic misal;
  // Bit 0 is never set in a real fetch; only bit 1 matters under 32-bit mode.
  assign misal = (mode == IALIGN_32) && fetch_addr[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q         <= 1'b0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      go_q    <= fetch_valid && !misal;
      fault_q <= fetch_valid && misal;
      if (fetch_valid && misal) fault_addr_q <= fetch_addr;
    end
  end
endmodule

// File: rtl/epc_reg.sv
module epc_reg
  import ialign_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter bit          HARDWIRE_B1 = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  ialign_e         mode,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            trap_we,
  input  logic [XLEN-1:0] trap_pc,
  output logic [XLEN-1:0] rd_val
);
  logic [XLEN-1:0] store_q;
  logic [XLEN-1:0] wsrc;
  logic [XLEN-1:0] wmasked;
  logic            clr_b1;
  logic            rd_b1;

  assign wsrc   = trap_we ? trap_pc : csr_wdata;
  assign clr_b1 = HARDWIRE_B1 && (mode == IALIGN_32);
  assign wmasked = {wsrc[XLEN-1:2], wsrc[1] & ~clr_b1, 1'b0};

  always_ff @(posedge clk) begin
    if (rst)                    store_q <= '0;
    else if (trap_we || csr_we) store_q <= wmasked;
  end

  assign rd_b1  = store_q[1] & (mode == IALIGN_16);
  assign rd_val = {store_q[XLEN-1:2], rd_b1, 1'b0};
endmodule

// File: rtl/ialign_epc_unit.sv
module ialign_epc_unit
  import ialign_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter bit          HARDWIRE_B1 = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cext_we,
  input  logic            cext_wdata,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_addr,
  input  logic            trap_enter,
  input  logic            trap_sel,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            xret,
  input  logic            xret_sel,
  input  logic [1:0]      epc_we,
  input  logic [XLEN-1:0] epc_wdata,
  output logic            ialign32_o,
  output logic            fetch_go_o,
  output logic            fault_o,
  output logic [XLEN-1:0] fault_addr_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] sepc_o,
  output logic            ret_valid_o,
  output logic [XLEN-1:0] ret_pc_o
);
  ialign_e         mode;
  logic [XLEN-1:0] epc_rd [NUM_EPC];

  ialign_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cext_we   (cext_we),
    .cext_wdata(cext_wdata),
    .mode_q    (mode)
  );

  fetch_align_chk #(.XLEN(XLEN)) u_fchk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .go_q        (fetch_go_o),
    .fault_q     (fault_o),
    .fault_addr_q(fault_addr_o)
  );

  for (genvar g = 0; g < NUM_EPC; g++) begin : g_epc
    logic trap_hit;
    assign trap_hit = trap_enter && (trap_sel == g[0]);
    epc_reg #(.XLEN(XLEN), .HARDWIRE_B1(HARDWIRE_B1)) u_epc (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode),
      .csr_we   (epc_we[g]),
      .csr_wdata(epc_wdata),
      .trap_we  (trap_hit),
      .trap_pc  (trap_pc),
      .rd_val   (epc_rd[g])
    );
  end

  assign ialign32_o = (mode == IALIGN_32);
  assign mepc_o     = epc_rd[SEL_M];
  assign sepc_o     = epc_rd[SEL_S];

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid_o <= 1'b0;
      ret_pc_o    <= '0;
    end else begin
      ret_valid_o <= xret;
      if (xret) ret_pc_o <= xret_sel ? epc_rd[SEL_S] : epc_rd[SEL_M];
    end
  end
endmodule

// File: rtl/ialign_epc_unit_chk.sv
module ialign_epc_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cext_we,
  input logic            cext_wdata,
  input logic            fetch_valid,
  input logic [XLEN-1:0] fetch_addr,
  input logic            xret,
  input logic            ialign32_o,
  input logic            fetch_go_o,
  input logic            fault_o,
  input logic [XLEN-1:0] fault_addr_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] sepc_o,
  input logic            ret_valid_o
);
  // R2/R3: a fault needs 32-bit mode, a valid fetch and address bit 1
  a_r2_fault_needs_strict: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> ($past(ialign32_o) && $past(fetch_valid) && $past(fetch_addr[1])));
  // R3: the reported address is the fetch that faulted
  a_r3_fault_addr: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (fault_addr_o == $past(fetch_addr)));
  // R3: a faulting fetch is suppressed
  a_r3_suppress: assert property (@(posedge clk) disable iff (rst)
    !(fault_o && fetch_go_o));
  // R4: the setting moves only on a write
  a_r4_setting_write: assert property (@(posedge clk) disable iff (rst)
    (ialign32_o != $past(ialign32_o)) |-> ($past(cext_we) && (ialign32_o == !$past(cext_wdata))));
  // R5: bit 0 never reads as one
  a_r5_bit0: assert property (@(posedge clk) disable iff (rst)
    (mepc_o[0] == 1'b0) && (sepc_o[0] == 1'b0));
  // R6: bit 1 hidden under 32-bit mode
  a_r6_bit1_hidden: assert property (@(posedge clk) disable iff (rst)
    ialign32_o |-> (mepc_o[1] == 1'b0 && sepc_o[1] == 1'b0));
  // R9: a return completes one cycle later
  a_r9_ret_pulse: assert property (@(posedge clk) disable iff (rst)
    ret_valid_o == $past(xret));
endmodule

bind ialign_epc_unit ialign_epc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cext_we     (cext_we),
  .cext_wdata  (cext_wdata),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .xret        (xret),
  .ialign32_o  (ialign32_o),
  .fetch_go_o  (fetch_go_o),
  .fault_o     (fault_o),
  .fault_addr_o(fault_addr_o),
  .mepc_o      (mepc_o),
  .sepc_o      (sepc_o),
  .ret_valid_o (ret_valid_o)
);

// File: tb/ialign_epc_unit_tb_top.sv
module ialign_epc_unit_tb_top;
  localparam int unsigned XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cext_we = 0, cext_wdata = 0, fetch_valid = 0;
  logic [XLEN-1:0] fetch_addr = '0, trap_pc = '0, epc_wdata = '0;
  logic trap_enter = 0, trap_sel = 0, xret = 0, xret_sel = 0;
  logic [1:0] epc_we = '0;

  logic            a32, go, flt, rv;
  logic [XLEN-1:0] faddr, mepc, sepc, rpc;
  logic            a32_h, go_h, flt_h, rv_h;
  logic [XLEN-1:0] faddr_h, mepc_h, sepc_h, rpc_h;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #10 clk = ~clk;

  ialign_epc_unit #(.XLEN(XLEN), .HARDWIRE_B1(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cext_we(cext_we), .cext_wdata(cext_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .trap_enter(trap_enter), .trap_sel(trap_sel), .trap_pc(trap_pc),
    .xret(xret), .xret_sel(xret_sel), .epc_we(epc_we), .epc_wdata(epc_wdata),
    .ialign32_o(a32), .fetch_go_o(go), .fault_o(flt), .fault_addr_o(faddr),
    .mepc_o(mepc), .sepc_o(sepc), .ret_valid_o(rv), .ret_pc_o(rpc));

  ialign_epc_unit #(.XLEN(XLEN), .HARDWIRE_B1(1'b1)) dut_hw_i (
    .clk(clk), .rst(rst), .cext_we(cext_we), .cext_wdata(cext_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .trap_enter(trap_enter), .trap_sel(trap_sel), .trap_pc(trap_pc),
    .xret(xret), .xret_sel(xret_sel), .epc_we(epc_we), .epc_wdata(epc_wdata),
    .ialign32_o(a32_h), .fetch_go_o(go_h), .fault_o(flt_h), .fault_addr_o(faddr_h),
    .mepc_o(mepc_h), .sepc_o(sepc_h), .ret_valid_o(rv_h), .ret_pc_o(rpc_h));

  // Reference model state, computed from the requirements
  logic            m32;
  logic [XLEN-1:0] st_m, st_s, st_mh, st_sh;

  function automatic logic [XLEN-1:0] stv(input logic [XLEN-1:0] d, input logic s32, input logic hw);
    stv = {d[XLEN-1:2], d[1] & ~(hw & s32), 1'b0};
  endfunction
  function automatic logic [XLEN-1:0] rdv(input logic [XLEN-1:0] q, input logic s32);
    rdv = s32 ? (q & ~XLEN'(3)) : (q & ~XLEN'(1));
  endfunction

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    cext_we = 0; fetch_valid = 0; trap_enter = 0; xret = 0; epc_we = '0;
  endtask

  task automatic check_epcs(input string req);
    chk(req, mepc,   rdv(st_m, m32));
    chk(req, sepc,   rdv(st_s, m32));
    chk(req, mepc_h, rdv(st_mh, m32));
    chk(req, sepc_h, rdv(st_sh, m32));
  endtask

  task automatic set_cext(input logic en);
    cext_we = 1; cext_wdata = en; tick(); idle();
    m32 = ~en;
    chk("R4 setting", {31'd0, a32}, {31'd0, m32});
  endtask

  task automatic do_fetch(input logic [XLEN-1:0] a, input string req);
    logic bad;
    bad = m32 & a[1];
    fetch_valid = 1; fetch_addr = a; tick(); idle();
    chk(req, {30'd0, flt, go}, {30'd0, bad, ~bad});
    if (bad) chk(req, faddr, a);
    chk(req, {31'd0, flt_h}, {31'd0, bad});
    tick();
    chk(req, {30'd0, flt, go}, 32'd0);
  endtask

  task automatic csr_wr(input logic [1:0] we, input logic [XLEN-1:0] d);
    epc_we = we; epc_wdata = d; tick(); idle();
    if (we[0]) begin st_m = stv(d, m32, 0); st_mh = stv(d, m32, 1); end
    if (we[1]) begin st_s = stv(d, m32, 0); st_sh = stv(d, m32, 1); end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m32 = 0; st_m = '0; st_s = '0; st_mh = '0; st_sh = '0;
    tick(); tick(); rst = 0; tick();
    // R1 reset state
    chk("R1 mode", {31'd0, a32}, 32'd0);
    chk("R1 outs", {29'd0, flt, go, rv}, 32'd0);
    chk("R1 mepc", mepc, '0);
    chk("R1 sepc", sepc, '0);

    // R2 / R3 sweep over both settings and all low address bits
    for (int mode = 0; mode < 2; mode++) begin
      set_cext(mode == 0);
      for (int hi = 0; hi < 8; hi++)
        for (int lo = 0; lo < 4; lo += 2)
          do_fetch({XLEN'(hi * 32'h1357_9bd0) & ~XLEN'(3)} | XLEN'(lo),
                   mode == 0 ? "R2 c16 fetch" : "R3 c32 fetch");
    end

    // R4: fetch in same cycle as disabling write uses the old setting
    set_cext(1);
    cext_we = 1; cext_wdata = 0; fetch_valid = 1; fetch_addr = 32'h0000_1002; tick(); idle();
    m32 = 1;
    chk("R4 same-cycle old rule", {30'd0, flt, go}, 32'd1);
    do_fetch(32'h0000_1006, "R4 next fetch faults");
    // re-enable: same-cycle fetch still faults, next does not
    cext_we = 1; cext_wdata = 1; fetch_valid = 1; fetch_addr = 32'h0000_200a; tick(); idle();
    m32 = 0;
    chk("R4 same-cycle strict", {30'd0, flt, go}, 32'd2);
    chk("R4 addr", faddr, 32'h0000_200a);
    do_fetch(32'h0000_200a, "R4 after enable");

    // R5 / R6 / R7: CSR writes with every low-bit pattern in both settings
    for (int mode = 0; mode < 2; mode++) begin
      set_cext(mode == 0);
      for (int lo = 0; lo < 4; lo++) begin
        csr_wr(2'b01, 32'hA5A5_0000 | XLEN'(lo));
        csr_wr(2'b10, 32'h5A5A_0010 | XLEN'(3 - lo));
        check_epcs("R5 R6 write read");
      end
    end
    // bit 1 written in 32-bit mode
    csr_wr(2'b11, 32'hCAFE_0003);
    check_epcs("R6 hidden under 32");
    set_cext(1);
    check_epcs("R6 R7 visible after return to 16");
    chk("R6 bit1 retained", {31'd0, mepc[1]}, 32'd1);
    chk("R7 bit1 cleared", {31'd0, mepc_h[1]}, 32'd0);

    // R8: trap entry to each register, and precedence over CSR write
    trap_enter = 1; trap_sel = 0; trap_pc = 32'h8000_0106; tick(); idle();
    st_m = stv(32'h8000_0106, m32, 0); st_mh = stv(32'h8000_0106, m32, 1);
    check_epcs("R8 trap to machine");
    set_cext(0);
    trap_enter = 1; trap_sel = 1; trap_pc = 32'h8000_0203;
    epc_we = 2'b11; epc_wdata = 32'h1111_1110; tick(); idle();
    st_s = stv(32'h8000_0203, 1, 0); st_sh = stv(32'h8000_0203, 1, 1);
    st_m = stv(32'h1111_1110, 1, 0); st_mh = stv(32'h1111_1110, 1, 1);
    check_epcs("R8 trap beats csr write");

    // R9: returns from each register, no fault
    set_cext(1);
    for (int s = 0; s < 2; s++) begin
      xret = 1; xret_sel = s[0]; tick(); idle();
      chk("R9 ret valid", {30'd0, rv, flt}, 32'd2);
      chk("R9 ret pc", rpc, s == 0 ? rdv(st_m, 0) : rdv(st_s, 0));
      tick();
      chk("R9 one pulse", {31'd0, rv}, 32'd0);
    end
    // return under 32-bit mode: masked target, then a misaligned fetch faults
    csr_wr(2'b01, 32'h0000_4002);
    set_cext(0);
    xret = 1; xret_sel = 0; tick(); idle();
    chk("R9 ret under 32", rpc, 32'h0000_4000);
    chk("R9 no fault", {31'd0, flt}, 32'd0);
    do_fetch(32'h0000_4002, "R3 fetch after return");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule